// File: doc/BRIEF.md
# Sixteen-Bit ALU With Overflow Word

This block carries out the two-operand arithmetic, logic and shift operations of a small 16-bit processor. Each operation takes a 4-bit opcode and two 16-bit operands, `opa` (the destination value) and `opb` (the source value). From these it forms a 16-bit result, a new value for a 16-bit overflow word, two write enables and the number of cycles the operation costs. The overflow word is a register held inside the block. Every arithmetic operation gives it its own meaning: a carry flag, a borrow mask, the high half of a product, a fractional quotient, or the bits shifted out.

The surrounding core decodes the operands and tells the block, through `dst_lit`, when the destination is a literal. In that case the result is not written back, but the overflow word still follows the operation. Division and modulo are combinational. A zero divisor gives zero and does not trap. Opcodes outside the supported set, and cycles with `op_valid` low, cause no writes.

Top module: `alu16_ovf`

## Requirements
- R1: Opcode 1 (copy) returns `opb`. Opcodes 9, 0xA and 0xB return `opa & opb`, `opa | opb` and `opa ^ opb`. All four cost 1 cycle and do not write the overflow word.
- R2: Opcode 2 returns `opa + opb` modulo 2^16. It sets the overflow word to 0x0001 when there is a carry out of bit 15 and to 0x0000 otherwise. Cost is 2.
- R3: Opcode 3 returns `opa - opb` modulo 2^16. It sets the overflow word to 0xFFFF on a borrow and to 0x0000 otherwise. Cost is 2.
- R4: Opcode 4 returns the low 16 bits of the 32-bit product and puts the high 16 bits into the overflow word. Cost is 2.
- R5: Opcode 5 with a nonzero `opb` returns `opa / opb`. It sets the overflow word to `((opa << 16) / opb) & 0xFFFF`, computed from the original `opa` and not from the quotient. Cost is 3.
- R6: Opcode 5 with `opb` = 0 returns 0 and sets the overflow word to 0.
- R7: Opcode 6 returns `opa % opb`, or 0 when `opb` = 0. It leaves the overflow word unchanged. Cost is 3.
- R8: Opcode 7 computes `opa << opb` in 32 bits. It returns bits 15:0 and puts bits 31:16 into the overflow word. A shift count of 32 or more gives 0 for both. Cost is 2.
- R9: Opcode 8 returns `opa >> opb` and sets the overflow word to `((opa << 16) >> opb) & 0xFFFF`. A shift count of 32 or more gives 0 for both. Cost is 2.
- R10: With `dst_lit` high, `res_we` stays low. The overflow word is still written for the operations that write it.
- R11: The overflow register resets to 0. It takes `ovf_next` at a clock edge where `ovf_we` is high and holds its value otherwise.
- R12: With `op_valid` low, or with an opcode of 0 or 0xC to 0xF, `res_we` and `ovf_we` are low, `cost` is 0 and `result` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | An operation is presented this cycle |
| opcode | input | 4 | Operation code |
| opa | input | 16 | Destination operand value |
| opb | input | 16 | Source operand value |
| dst_lit | input | 1 | The destination is a literal |
| result | output | 16 | Operation result |
| res_we | output | 1 | Write the result to the destination |
| ovf_we | output | 1 | The overflow word is written at the next edge |
| ovf_next | output | 16 | New overflow word value |
| ovf_q | output | 16 | Current overflow word |
| cost | output | 2 | Cycle cost of the operation |

## Verification
The vectors target the carry and borrow edges (0xFFFF+1 and 1-2) and the largest product. They also cover a divide whose quotient differs from its fractional overflow: a design that used the quotient for the overflow would return 0 where 0x8000 is expected. Zero divisors on both divide and modulo catch a design that returns X or stale data. A modulo placed straight after a multiply shows whether the overflow word is wrongly cleared. Shift counts of 1, 20, 31 and 32 separate correct 32-bit truncation from a 16-bit shifter or from a wrap of the count. Literal destinations and unsupported opcodes show whether a design writes when it must not.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

    typedef enum logic [3:0] {
        OP_NONE = 4'h0,
        OP_SET  = 4'h1,
        OP_ADD  = 4'h2,
        OP_SUB  = 4'h3,
        OP_MUL  = 4'h4,
        OP_DIV  = 4'h5,
        OP_MOD  = 4'h6,
        OP_SHL  = 4'h7,
        OP_SHR  = 4'h8,
        OP_AND  = 4'h9,
        OP_BOR  = 4'hA,
        OP_XOR  = 4'hB
    } alu_op_e;

    localparam int COST_W = 2;

    // cycle price per operation; 0 marks an unsupported code
    function automatic logic [COST_W-1:0] op_cost(input alu_op_e op);
        case (op)
            OP_SET, OP_AND, OP_BOR, OP_XOR:         op_cost = 2'd1;
            OP_ADD, OP_SUB, OP_MUL, OP_SHL, OP_SHR: op_cost = 2'd2;
            OP_DIV, OP_MOD:                         op_cost = 2'd3;
            default:                                op_cost = 2'd0;
        endcase
    endfunction

    // operations that replace the overflow word
    function automatic logic writes_ovf(input alu_op_e op);
        case (op)
            OP_ADD, OP_SUB, OP_MUL, OP_DIV, OP_SHL, OP_SHR: writes_ovf = 1'b1;
            default:                                        writes_ovf = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/alu16_arith.sv
module alu16_arith #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] add_res,
    output logic [W-1:0] add_ovf,
    output logic [W-1:0] sub_res,
    output logic [W-1:0] sub_ovf,
    output logic [W-1:0] mul_res,
    output logic [W-1:0] mul_ovf
);
    logic [W:0]     sum_x;
    logic [W:0]     dif_x;
    logic [2*W-1:0] prod;

    always_comb begin
        sum_x   = {1'b0, a} + {1'b0, b};
        dif_x   = {1'b0, a} - {1'b0, b};
        prod    = {{W{1'b0}}, a} * {{W{1'b0}}, b};
        add_res = sum_x[W-1:0];
        add_ovf = {{(W-1){1'b0}}, sum_x[W]};
        sub_res = dif_x[W-1:0];
        sub_ovf = {W{dif_x[W]}};
        mul_res = prod[W-1:0];
        mul_ovf = prod[2*W-1:W];
    end
endmodule

// File: rtl/alu16_shift.sv
module alu16_shift #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] shl_res,
    output logic [W-1:0] shl_ovf,
    output logic [W-1:0] shr_res,
    output logic [W-1:0] shr_ovf
);
    localparam int CW = $clog2(2*W);

    logic           too_far;
    logic [CW-1:0]  amt;
    logic [2*W-1:0] up;
    logic [2*W-1:0] down;

    always_comb begin
        too_far = |b[W-1:CW];
        amt     = b[CW-1:0];
        up      = {{W{1'b0}}, a} << amt;
        down    = {a, {W{1'b0}}} >> amt;
        shl_res = too_far ? '0 : up[W-1:0];
        shl_ovf = too_far ? '0 : up[2*W-1:W];
        shr_res = too_far ? '0 : down[2*W-1:W];
        shr_ovf = too_far ? '0 : down[W-1:0];
    end
endmodule

// File: rtl/alu16_divmod.sv
module alu16_divmod #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] div_res,
    output logic [W-1:0] div_ovf,
    output logic [W-1:0] mod_res
);
    logic           zero_b;
    logic [W-1:0]   safe_b;
    logic [2*W-1:0] frac;

    always_comb begin
        zero_b  = (b == '0);
        safe_b  = zero_b ? {{(W-1){1'b0}}, 1'b1} : b;
        frac    = {a, {W{1'b0}}} / {{W{1'b0}}, safe_b};
        div_res = zero_b ? '0 : a / safe_b;
        div_ovf = zero_b ? '0 : frac[W-1:0];
        mod_res = zero_b ? '0 : a % safe_b;
    end

    // R7: a remainder is always below a nonzero divisor
    a_r7_rem_below_div: assert property (@(posedge clk) disable iff (rst)
        (b != '0) |-> (mod_res < b));

    // R5: quotient times divisor never exceeds the dividend
    a_r5_quot_bound: assert property (@(posedge clk) disable iff (rst)
        (b != '0) |-> ({{W{1'b0}}, div_res} * {{W{1'b0}}, b} <= {{W{1'b0}}, a}));
endmodule

// File: rtl/alu16_ovf.sv
module alu16_ovf
    import alu16_pkg::*;
#(
    parameter int W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic [3:0]        opcode,
    input  logic [W-1:0]      opa,
    input  logic [W-1:0]      opb,
    input  logic              dst_lit,
    output logic [W-1:0]      result,
    output logic              res_we,
    output logic              ovf_we,
    output logic [W-1:0]      ovf_next,
    output logic [W-1:0]      ovf_q,
    output logic [COST_W-1:0] cost
);
    alu_op_e op;
    logic [W-1:0] add_r, add_o, sub_r, sub_o, mul_r, mul_o;
    logic [W-1:0] shl_r, shl_o, shr_r, shr_o;
    logic [W-1:0] div_r, div_o, mod_r;
    logic [W-1:0] res_sel, ovf_sel;
    logic         supported;

    assign op = alu_op_e'(opcode);

    alu16_arith #(.W(W)) u_arith (
        .a(opa), .b(opb),
        .add_res(add_r), .add_ovf(add_o),
        .sub_res(sub_r), .sub_ovf(sub_o),
        .mul_res(mul_r), .mul_ovf(mul_o)
    );

    alu16_shift #(.W(W)) u_shift (
        .a(opa), .b(opb),
        .shl_res(shl_r), .shl_ovf(shl_o),
        .shr_res(shr_r), .shr_ovf(shr_o)
    );

    alu16_divmod #(.W(W)) u_divmod (
        .clk(clk), .rst(rst), .a(opa), .b(opb),
        .div_res(div_r), .div_ovf(div_o), .mod_res(mod_r)
    );

    always_comb begin
        res_sel = '0;
        ovf_sel = '0;
        case (op)
            OP_SET: res_sel = opb;
            OP_ADD: begin res_sel = add_r; ovf_sel = add_o; end
            OP_SUB: begin res_sel = sub_r; ovf_sel = sub_o; end
            OP_MUL: begin res_sel = mul_r; ovf_sel = mul_o; end
            OP_DIV: begin res_sel = div_r; ovf_sel = div_o; end
            OP_MOD: res_sel = mod_r;
            OP_SHL: begin res_sel = shl_r; ovf_sel = shl_o; end
            OP_SHR: begin res_sel = shr_r; ovf_sel = shr_o; end
            OP_AND: res_sel = opa & opb;
            OP_BOR: res_sel = opa | opb;
            OP_XOR: res_sel = opa ^ opb;
            default: ;
        endcase
        supported = (op_cost(op) != '0);
        result    = op_valid ? res_sel : '0;
        ovf_next  = ovf_sel;
        cost      = op_valid ? op_cost(op) : '0;
        res_we    = op_valid && supported && !dst_lit;
        ovf_we    = op_valid && writes_ovf(op);
    end

    always_ff @(posedge clk) begin
        if (rst)         ovf_q <= '0;
        else if (ovf_we) ovf_q <= ovf_next;
    end

    // R10: a literal destination is never written
    a_r10_lit_no_write: assert property (@(posedge clk) disable iff (rst)
        dst_lit |-> !res_we);

    // R11: the overflow word loads the offered value
    a_r11_ovf_load: assert property (@(posedge clk) disable iff (rst)
        ovf_we |=> (ovf_q == $past(ovf_next)));

    // R11: the overflow word holds without a write
    a_r11_ovf_hold: assert property (@(posedge clk) disable iff (rst)
        !ovf_we |=> $stable(ovf_q));

    // R12: an idle cycle writes nothing and costs nothing
    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !op_valid |-> (!res_we && !ovf_we && cost == '0));

    // R1: any write comes from a costed operation
    a_r1_write_costed: assert property (@(posedge clk) disable iff (rst)
        (res_we || ovf_we) |-> (cost != '0));
endmodule

// File: tb/tb_alu16_ovf.sv
`timescale 1ns/1ps
module tb_alu16_ovf;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic [3:0]  opcode = '0;
    logic [15:0] opa = '0, opb = '0;
    logic        dst_lit = 1'b0;
    logic [15:0] result, ovf_next, ovf_q;
    logic        res_we, ovf_we;
    logic [1:0]  cost;

    int checks = 0;
    int errors = 0;
    logic [15:0] exp_o = 16'h0;

    always #2.5 clk = ~clk;

    alu16_ovf dut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .opcode(opcode),
        .opa(opa), .opb(opb), .dst_lit(dst_lit), .result(result),
        .res_we(res_we), .ovf_we(ovf_we), .ovf_next(ovf_next),
        .ovf_q(ovf_q), .cost(cost)
    );

    // op, a, b, lit, result, res_we, ovf_we, ovf, cost
    localparam int NV = 28;
    localparam logic [72:0] VEC [NV] = '{
        {4'h1,16'h1234,16'hABCD,1'b0,16'hABCD,1'b1,1'b0,16'h0000,2'd1},
        {4'h2,16'hFFFF,16'h0001,1'b0,16'h0000,1'b1,1'b1,16'h0001,2'd2},
        {4'h2,16'h1000,16'h2000,1'b0,16'h3000,1'b1,1'b1,16'h0000,2'd2},
        {4'h3,16'h0001,16'h0002,1'b0,16'hFFFF,1'b1,1'b1,16'hFFFF,2'd2},
        {4'h3,16'h0005,16'h0003,1'b0,16'h0002,1'b1,1'b1,16'h0000,2'd2},
        {4'h4,16'h1234,16'h0100,1'b0,16'h3400,1'b1,1'b1,16'h0012,2'd2},
        {4'h4,16'hFFFF,16'hFFFF,1'b0,16'h0001,1'b1,1'b1,16'hFFFE,2'd2},
        {4'h6,16'h0007,16'h0003,1'b0,16'h0001,1'b1,1'b0,16'h0000,2'd3},
        {4'h6,16'h1234,16'h0000,1'b0,16'h0000,1'b1,1'b0,16'h0000,2'd3},
        {4'h5,16'h0007,16'h0002,1'b0,16'h0003,1'b1,1'b1,16'h8000,2'd3},
        {4'h5,16'h0005,16'h0002,1'b0,16'h0002,1'b1,1'b1,16'h8000,2'd3},
        {4'h5,16'h0001,16'h0003,1'b0,16'h0000,1'b1,1'b1,16'h5555,2'd3},
        {4'h5,16'h1234,16'h0000,1'b0,16'h0000,1'b1,1'b1,16'h0000,2'd3},
        {4'h7,16'h8001,16'h0001,1'b0,16'h0002,1'b1,1'b1,16'h0001,2'd2},
        {4'h7,16'h1234,16'h0014,1'b0,16'h0000,1'b1,1'b1,16'h2340,2'd2},
        {4'h7,16'h0001,16'h001F,1'b0,16'h0000,1'b1,1'b1,16'h8000,2'd2},
        {4'h7,16'h1234,16'h0020,1'b0,16'h0000,1'b1,1'b1,16'h0000,2'd2},
        {4'h8,16'h8001,16'h0001,1'b0,16'h4000,1'b1,1'b1,16'h8000,2'd2},
        {4'h8,16'h1234,16'h0014,1'b0,16'h0000,1'b1,1'b1,16'h0123,2'd2},
        {4'h8,16'hFFFF,16'h0020,1'b0,16'h0000,1'b1,1'b1,16'h0000,2'd2},
        {4'h9,16'hF0F0,16'hFF00,1'b0,16'hF000,1'b1,1'b0,16'h0000,2'd1},
        {4'hA,16'hF0F0,16'h0F0F,1'b0,16'hFFFF,1'b1,1'b0,16'h0000,2'd1},
        {4'hB,16'hFFFF,16'h00FF,1'b0,16'hFF00,1'b1,1'b0,16'h0000,2'd1},
        {4'h2,16'hFFFF,16'h0002,1'b1,16'h0001,1'b0,1'b1,16'h0001,2'd2},
        {4'h1,16'h1234,16'h5678,1'b1,16'h5678,1'b0,1'b0,16'h0000,2'd1},
        {4'h4,16'h0002,16'h8000,1'b1,16'h0000,1'b0,1'b1,16'h0001,2'd2},
        {4'h0,16'h1111,16'h2222,1'b0,16'h0000,1'b0,1'b0,16'h0000,2'd0},
        {4'hC,16'h1111,16'h1111,1'b0,16'h0000,1'b0,1'b0,16'h0000,2'd0}
    };

    function automatic string tag_of(input logic [3:0] op, input logic lit);
        if (lit) return "R10";
        case (op)
            4'h2: return "R2";
            4'h3: return "R3";
            4'h4: return "R4";
            4'h5: return "R5/R6";
            4'h6: return "R7";
            4'h7: return "R8";
            4'h8: return "R9";
            4'h0, 4'hC: return "R12";
            default: return "R1";
        endcase
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    initial begin
        #100000;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=0", 1);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R11", "reset ovf_q", ovf_q, 16'h0);
        chk("R12", "reset res_we", {15'b0, res_we}, 16'h0);
        @(negedge clk) rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            logic [72:0] v;
            string t;
            v = VEC[i];
            t = tag_of(v[72:69], v[36]);
            @(negedge clk);
            op_valid = 1'b1;
            opcode = v[72:69]; opa = v[68:53]; opb = v[52:37]; dst_lit = v[36];
            #1;
            chk(t, "result", result, v[35:20]);
            chk(t, "res_we", {15'b0, res_we}, {15'b0, v[19]});
            chk(t, "ovf_we", {15'b0, ovf_we}, {15'b0, v[18]});
            chk(t, "cost", {14'b0, cost}, {14'b0, v[1:0]});
            if (v[18]) begin
                chk(t, "ovf_next", ovf_next, v[17:2]);
                exp_o = v[17:2];
            end
            @(posedge clk); #1;
            chk("R11", "ovf_q after op", ovf_q, exp_o);
        end

        // R12: valid low leaves overflow word and writes alone
        @(negedge clk);
        op_valid = 1'b0; opcode = 4'h2; opa = 16'hFFFF; opb = 16'hFFFF; dst_lit = 1'b0;
        #1;
        chk("R12", "idle ovf_we", {15'b0, ovf_we}, 16'h0);
        chk("R12", "idle cost", {14'b0, cost}, 16'h0);
        @(posedge clk); #1;
        chk("R12", "idle ovf_q", ovf_q, exp_o);

        // R11: load a nonzero value then reset clears it
        @(negedge clk);
        op_valid = 1'b1; opcode = 4'h4; opa = 16'hFFFF; opb = 16'hFFFF;
        @(posedge clk); #1;
        chk("R11", "ovf_q load", ovf_q, 16'hFFFE);
        @(negedge clk);
        op_valid = 1'b0; rst = 1'b1;
        @(posedge clk); #1;
        chk("R11", "ovf_q reset", ovf_q, 16'h0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule